// File: doc/BRIEF.md
# ADC Conversion Burst Pacer

This block paces a burst of conversions on a serial multichannel ADC whose conversions are started from a dedicated active-low pin. A host request supplies how many conversions to run, the ADC reference mode and whether a temperature reading is wanted. The block then drives the active-low start strobe once per conversion. It holds the strobe low for an acquisition window and releases it to launch the conversion. Before it issues the next strobe, it waits for the ADC's active-low end-of-conversion line to fall.

The acquisition window depends on the request. A temperature request needs only a short pulse, because the ADC times its own reference wake-up and measurement. Reference modes that power the internal reference on demand need an extra wake-up interval on top of the normal acquisition time. All windows are cycle counts derived from a clock-frequency parameter and rounded up.

Once the last conversion has ended, a done flag tells the host that the ADC result FIFO may be read. If end-of-conversion never arrives, a watchdog aborts the burst and raises a sticky timeout flag.

Top module: `adc_burst_pacer`

## Requirements
- R1: After reset `cnvst_n` is 1 and `busy`, `done` and `timeout` are 0.
- R2: With `temp_req`=0 and `ref_mode` 01 or 11, each strobe low pulse lasts exactly ceil(1400 ns × CLK_HZ / 1e9) cycles (140 at 100 MHz).
- R3: With `temp_req`=0 and `ref_mode` 00 or 10, each strobe low pulse lasts exactly ceil(46400 ns × CLK_HZ / 1e9) cycles (4640 at 100 MHz).
- R4: With `temp_req`=1, each strobe low pulse lasts exactly ceil(40 ns × CLK_HZ / 1e9) cycles (4 at 100 MHz), whatever `ref_mode` is.
- R5: `eoc_n` passes through a two-flop synchronizer. After the first pulse of a burst, the strobe falls only on the third rising clock edge after `eoc_n` falls, and never while `eoc_n` is high.
- R6: A burst with `conv_count` N (1 to MAX_CONV) issues exactly N strobe pulses. `busy` is 1 from the accepted request until the last end-of-conversion. `done` then rises and holds until the next accepted request.
- R7: A request with `conv_count` 0 sets `done` on the next clock edge, without any strobe pulse and without raising `busy`.
- R8: A `conv_count` above MAX_CONV (514) is clamped, and the burst issues exactly MAX_CONV pulses.
- R9: A `start` pulse while `busy` is 1 is ignored: the running burst keeps its pulse count and pulse width.
- R10: If `eoc_n` does not fall within EOC_TIMEOUT cycles after a strobe release, the burst aborts. In that case `cnvst_n` stays 1, `busy` and `done` are 0, and `timeout` is set and held until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request, sampled when idle |
| conv_count | input | CNT_W | Number of conversions requested |
| ref_mode | input | 2 | ADC reference mode; 00 and 10 need reference wake-up |
| temp_req | input | 1 | Request includes a temperature measurement |
| eoc_n | input | 1 | Asynchronous active-low end-of-conversion from the ADC |
| cnvst_n | output | 1 | Active-low conversion-start strobe to the ADC |
| busy | output | 1 | Burst in progress |
| done | output | 1 | All requested conversions finished; FIFO may be read |
| timeout | output | 1 | Sticky: last burst aborted for lack of end-of-conversion |

## Verification
The assertions assume the ADC behaves as specified:
- `eoc_n` rises after each strobe fall and falls once per conversion, some time after the strobe is released.
- `eoc_n` is otherwise quiet.

The bench models such an ADC. It raises `eoc_n` on each strobe fall and drops it a fixed 205 ns after each release. The drop falls mid-cycle, so the synchronizer latency is unambiguous. For the timeout case the model simply withholds the drop, then restores `eoc_n` low before the next request.

// File: rtl/adc_burst_pacer.sv
`timescale 1ns/1ps
module adc_burst_pacer #(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int MAX_CONV = 514,
  parameter int CNT_W = 10,
  parameter int EOC_TIMEOUT = 1000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] conv_count,
  input  logic [1:0]       ref_mode,
  input  logic             temp_req,
  input  logic             eoc_n,
  output logic             cnvst_n,
  output logic             busy,
  output logic             done,
  output logic             timeout
);
  localparam longint unsigned NS_S = 64'd1_000_000_000;
  localparam int ACQ_NORM = int'((64'd1400  * CLK_HZ + NS_S - 1) / NS_S);
  localparam int ACQ_WAKE = int'((64'd46400 * CLK_HZ + NS_S - 1) / NS_S);
  localparam int ACQ_TEMP = int'((64'd40    * CLK_HZ + NS_S - 1) / NS_S);
  localparam int TMR_MAX  = (ACQ_WAKE > EOC_TIMEOUT) ? ACQ_WAKE : EOC_TIMEOUT;
  localparam int TW       = $clog2(TMR_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} st_t;

  st_t              state;
  logic [TW-1:0]    timer;
  logic [CNT_W-1:0] left;
  logic             cfg_temp, cfg_wake;
  logic [2:0]       eoc_s;
  logic             eoc_fall;
  logic [CNT_W-1:0] req_in;

  function automatic logic [TW-1:0] acq_len(input logic t, input logic w);
    if (t)      return TW'(ACQ_TEMP);
    else if (w) return TW'(ACQ_WAKE);
    else        return TW'(ACQ_NORM);
  endfunction

  wire wake_in = (ref_mode == 2'b00) || (ref_mode == 2'b10);
  assign req_in   = (conv_count > CNT_W'(MAX_CONV)) ? CNT_W'(MAX_CONV) : conv_count;
  assign eoc_fall = eoc_s[2] & ~eoc_s[1];
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) eoc_s <= 3'b111;
    else        eoc_s <= {eoc_s[1:0], eoc_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      timer    <= '0;
      left     <= '0;
      cfg_temp <= 1'b0;
      cfg_wake <= 1'b0;
      cnvst_n  <= 1'b1;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          timeout <= 1'b0;
          done    <= (req_in == '0);
          if (req_in != '0) begin
            state    <= S_ACQ;
            cnvst_n  <= 1'b0;
            cfg_temp <= temp_req;
            cfg_wake <= wake_in;
            timer    <= acq_len(temp_req, wake_in) - 1'b1;
            left     <= req_in;
          end
        end
        S_ACQ: begin
          if (timer == '0) begin
            cnvst_n <= 1'b1;
            state   <= S_CONV;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_CONV: begin
          if (eoc_fall) begin
            if (left == CNT_W'(1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              left    <= left - 1'b1;
              state   <= S_ACQ;
              cnvst_n <= 1'b0;
              timer   <= acq_len(cfg_temp, cfg_wake) - 1'b1;
            end
          end else if (timer == TW'(EOC_TIMEOUT - 1)) begin
            state   <= S_IDLE;
            timeout <= 1'b1;
            timer   <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [TW:0]      low_cnt;
  logic [CNT_W-1:0] pulse_cnt, req_q;
  logic             strobe_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      pulse_cnt <= '0;
      req_q     <= '0;
      strobe_q  <= 1'b1;
    end else begin
      strobe_q <= cnvst_n;
      low_cnt  <= cnvst_n ? '0 : low_cnt + 1'b1;
      if (state == S_IDLE && start) begin
        pulse_cnt <= '0;
        req_q     <= req_in;
      end else if (strobe_q && !cnvst_n) begin
        pulse_cnt <= pulse_cnt + 1'b1;
      end
    end
  end

  AST_ACQ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnvst_n) && !timeout |-> low_cnt >= (TW+1)'(acq_len(cfg_temp, cfg_wake))); // R2
  AST_TEMP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnvst_n) && cfg_temp |-> low_cnt == (TW+1)'(ACQ_TEMP)); // R4
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnvst_n) |-> $past(state == S_IDLE || eoc_fall)); // R5
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> pulse_cnt == req_q); // R6
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cnvst_n && !busy && !done)); // R10
endmodule

// File: tb/tb_adc_burst_pacer.sv
`timescale 1ns/1ps
module tb_adc_burst_pacer;
  logic clk = 0, rst_n = 0, start = 0, temp_req = 0, eoc_n = 0;
  logic [9:0] conv_count = 0;
  logic [1:0] ref_mode = 0;
  logic cnvst_n, busy, done, timeout;

  adc_burst_pacer dut (.clk(clk), .rst_n(rst_n), .start(start), .conv_count(conv_count),
    .ref_mode(ref_mode), .temp_req(temp_req), .eoc_n(eoc_n), .cnvst_n(cnvst_n),
    .busy(busy), .done(done), .timeout(timeout));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int pulses, early, width_bad, gap_bad, exp_w;
  bit first, mute = 0, busy_seen, finished = 0;
  realtime tf, te;

  task automatic chk(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int cyc(int ns);
    return (ns + 9) / 10;
  endfunction

  always begin
    @(negedge cnvst_n);
    tf = $realtime;
    pulses++;
    if (eoc_n) early++;
    else if (!first && ((tf - te) <= 20.0 || (tf - te) > 30.0)) gap_bad++;
    first = 0;
    eoc_n = 1;
    @(posedge cnvst_n);
    if (($realtime - tf) != exp_w * 10.0) width_bad++;
    #205;
    if (!mute) begin
      eoc_n = 0;
      te = $realtime;
    end
  end

  always @(posedge clk) if (busy) busy_seen = 1;

  task automatic run(int cnt, bit [1:0] r, bit t, int exp_n, int ew, bit interfere, string tag);
    int g;
    pulses = 0; early = 0; width_bad = 0; gap_bad = 0; first = 1; busy_seen = 0; exp_w = ew;
    @(negedge clk);
    conv_count = 10'(cnt); ref_mode = r; temp_req = t; start = 1;
    @(negedge clk);
    start = 0;
    g = 0;
    while (!done && !timeout && g < 150000) begin
      @(negedge clk);
      g++;
      if (interfere && g == 10) begin
        conv_count = 10'd7; ref_mode = 2'b00; temp_req = 0; start = 1;
      end else start = 0;
    end
    @(negedge clk);
    chk(pulses == exp_n, tag, pulses, exp_n);
    chk(width_bad == 0, tag, width_bad, 0);
    chk(early == 0 && gap_bad == 0, "R5", early + gap_bad, 0);
    chk(done == 1 && busy == 0 && timeout == 0, "R6", {done, busy, timeout}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnvst_n == 1 && busy == 0 && done == 0 && timeout == 0, "R1",
        {cnvst_n, busy, done, timeout}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(cnvst_n == 1 && busy == 0 && done == 0 && timeout == 0, "R1",
        {cnvst_n, busy, done, timeout}, 4'b1000);

    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 2; t++) begin
        int w;
        w = t ? cyc(40) : (m[0] ? cyc(1400) : cyc(46400));
        run(2, 2'(m), 1'(t), 2, w, 0, t ? "R4" : (m[0] ? "R2" : "R3"));
      end

    for (int n = 1; n <= 6; n++) run(n, 2'b01, 1, n, cyc(40), 0, "R6");
    run(3, 2'b11, 0, 3, cyc(1400), 0, "R6");

    run(0, 2'b01, 0, 0, cyc(1400), 0, "R7");
    chk(busy_seen == 0, "R7", busy_seen, 0);

    run(514, 2'b01, 1, 514, cyc(40), 0, "R8");
    run(600, 2'b01, 1, 514, cyc(40), 0, "R8");
    run(1023, 2'b11, 1, 514, cyc(40), 0, "R8");

    run(3, 2'b01, 1, 3, cyc(40), 1, "R9");

    mute = 1;
    pulses = 0; first = 1; exp_w = cyc(40);
    @(negedge clk);
    conv_count = 10'd2; ref_mode = 2'b01; temp_req = 1; start = 1;
    @(negedge clk);
    start = 0;
    for (int g = 0; g < 5000 && !timeout; g++) @(negedge clk);
    chk(timeout == 1, "R10", timeout, 1);
    chk(done == 0 && busy == 0 && cnvst_n == 1, "R10", {done, busy, cnvst_n}, 3'b001);
    chk(pulses == 1, "R10", pulses, 1);
    repeat (50) @(negedge clk);
    chk(timeout == 1 && cnvst_n == 1, "R10", {timeout, cnvst_n}, 2'b11);
    mute = 0;
    eoc_n = 0;
    repeat (3) @(negedge clk);
    run(2, 2'b01, 1, 2, cyc(40), 0, "R10");

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule